// File: doc/BRIEF.md
# Signed Per-Phase Channel Delay Trimmer

This block trims the relative timing of three voltage/current sample pairs, one pair for each phase of a three-phase measurement front end. Every current sample stream goes through a fixed delay line of 16 sample ticks. The voltage stream of the same phase goes through a delay line whose length is 16 ticks plus a signed 5-bit calibration code. A positive code therefore delays the voltage against its current, and a negative code advances it. The full code range from -16 to +15 maps to voltage delays of 0 to 31 ticks. Transducer phase errors of a fraction of a degree can be cancelled this way.

Samples arrive as strobed words, normally one per phase every 12 master-clock cycles. At a 10 MHz master clock one code step is therefore 1.2 µs. Each phase has its own code register, written through a small select/data port. A new code is used from the first sample strobe after the write. Both streams of a phase leave the block together, registered, with a valid flag one clock after the input strobe. A delay line gives zero until it has seen as many samples as its current delay.

Top module: `chan_delay_trim`

## Requirements
- R1: After synchronous reset all output words are zero, all valid flags are low and every phase code is 0.
- R2: `out_vld[p]` is high in exactly the clock cycles that follow a cycle with `smp_vld[p]` high.
- R3: On each strobe of phase p, `curr_out[p]` becomes the current sample taken 16 strobes earlier on that phase.
- R4: On each strobe, `volt_out[p]` becomes the voltage sample taken 16+c strobes earlier, where c is the phase code read as 5-bit two's complement (5'h10 = -16 … 5'h0F = +15; for example 5'h1C = -4 gives 12 strobes).
- R5: With code 0, the voltage and current outputs of a phase keep exactly the same sample alignment as their inputs.
- R6: With code -16 (5'h10) the voltage path has no delay: `volt_out[p]` is the voltage sample presented in the same strobe.
- R7: While a phase has received fewer earlier samples than the delay its path needs, that path outputs zero on the strobe.
- R8: A write with `cfg_we` high loads `cfg_code` into the code of phase A, B or C for `cfg_sel` = 0, 1 or 2. A write with `cfg_sel` = 3 changes no code.
- R9: A code write in the same cycle as a strobe does not affect that strobe. The new code applies from the next strobe.
- R10: Between strobes, `volt_out` and `curr_out` hold their values.
- R11: Each phase's delay follows only its own code and its own strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 3 | Per-phase sample strobe (bit 0 = A) |
| volt_in | input | 3x24 | Voltage samples, one word per phase |
| curr_in | input | 3x24 | Current samples, one word per phase |
| cfg_we | input | 1 | Code write enable |
| cfg_sel | input | 2 | Code register select: 0=A, 1=B, 2=C, 3=unused |
| cfg_code | input | 5 | Signed calibration code to write |
| volt_out | output | 3x24 | Delay-trimmed voltage samples |
| curr_out | output | 3x24 | Fixed-delay current samples |
| out_vld | output | 3 | Per-phase output valid |

## Verification
The two functions that can meet in one clock are a code write and a sample strobe on the same phase. The bench provokes this by asserting `cfg_we` for phase A in the strobe cycle itself. A behavioural model reads codes only before it applies the write, so it expects that strobe to use the old delay and the following strobe to use the new one. The trimmed outputs are then compared with the model on every clock. Further cases are ramps and single-sample impulses under codes -16, -4, 0 and +15. These show the exact delay, the fill-time zeros, and whether the phases stay independent.

// File: rtl/chan_trim_pkg.sv
package chan_trim_pkg;
  parameter int unsigned SMP_W  = 24;
  parameter int unsigned CODE_W = 5;
  parameter int unsigned NPH    = 3;

  localparam int unsigned PTR_W = CODE_W;
  localparam int unsigned NOM   = 2 ** (CODE_W - 1);
  localparam int unsigned SEL_W = (NPH > 1) ? $clog2(NPH + 1) : 1;

  typedef logic [SMP_W-1:0] smp_t;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/trim_ring.sv
module trim_ring #(
  parameter int unsigned W  = 24,
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] dly,
  output logic [W-1:0]  dout,
  output logic          dout_vld
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [AW:0] FULL  = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_addr;
  logic [AW:0]   fill;
  logic          enough;

  assign rd_addr = wr_ptr - dly;
  assign enough  = (fill >= {1'b0, dly});

  always_ff @(posedge clk) begin
    if (wr_stb) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      fill     <= '0;
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= wr_stb;
      if (wr_stb) begin
        wr_ptr <= wr_ptr + 1'b1;
        if (fill != FULL) fill <= fill + 1'b1;
        if (dly == '0)    dout <= din;
        else if (enough)  dout <= mem[rd_addr];
        else              dout <= '0;
      end
    end
  end

  a_r2_vld_after_stb: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> dout_vld);
  a_r2_no_vld: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> !dout_vld);
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_stb && !$past(rst)) |=> $stable(dout));
  a_r7_fill_zero: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && dly != '0 && fill < {1'b0, dly}) |=> dout == '0);
  a_r6_bypass: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && dly == '0) |=> dout == $past(din));
endmodule

// File: rtl/trim_cal_bank.sv
module trim_cal_bank #(
  parameter int unsigned NPH   = 3,
  parameter int unsigned CW    = 5,
  parameter int unsigned SEL_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [SEL_W-1:0]         sel,
  input  logic [CW-1:0]            wdata,
  output logic [NPH-1:0][CW-1:0]   codes
);
  for (genvar p = 0; p < NPH; p++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                             codes[p] <= '0;
      else if (we && sel == SEL_W'(p))     codes[p] <= wdata;
    end
  end

  a_r8_spare_sel: assert property (@(posedge clk) disable iff (rst)
    (we && sel >= SEL_W'(NPH)) |=> $stable(codes));
  a_r1_reset_codes: assert property (@(posedge clk)
    rst |=> codes == '0);
endmodule

// File: rtl/chan_delay_trim.sv
module chan_delay_trim
  import chan_trim_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NPH-1:0]             smp_vld,
  input  logic [NPH-1:0][SMP_W-1:0]  volt_in,
  input  logic [NPH-1:0][SMP_W-1:0]  curr_in,
  input  logic                       cfg_we,
  input  logic [SEL_W-1:0]           cfg_sel,
  input  logic [CODE_W-1:0]          cfg_code,
  output logic [NPH-1:0][SMP_W-1:0]  volt_out,
  output logic [NPH-1:0][SMP_W-1:0]  curr_out,
  output logic [NPH-1:0]             out_vld
);
  logic [NPH-1:0][CODE_W-1:0] codes;
  logic [NPH-1:0]             ivld;

  trim_cal_bank #(.NPH(NPH), .CW(CODE_W), .SEL_W(SEL_W)) u_cal (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_code), .codes(codes)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic [PTR_W-1:0] vdly;
    // signed code around the centred nominal delay
    assign vdly = PTR_W'(NOM) + PTR_W'(codes[p]);

    trim_ring #(.W(SMP_W), .AW(PTR_W)) u_vring (
      .clk(clk), .rst(rst), .wr_stb(smp_vld[p]), .din(volt_in[p]),
      .dly(vdly), .dout(volt_out[p]), .dout_vld(out_vld[p])
    );

    trim_ring #(.W(SMP_W), .AW(PTR_W)) u_iring (
      .clk(clk), .rst(rst), .wr_stb(smp_vld[p]), .din(curr_in[p]),
      .dly(PTR_W'(NOM)), .dout(curr_out[p]), .dout_vld(ivld[p])
    );

    a_r11_paths_paired: assert property (@(posedge clk) disable iff (rst)
      out_vld[p] == ivld[p]);
    a_r5_zero_code: assert property (@(posedge clk) disable iff (rst)
      (smp_vld[p] && codes[p] == '0) |-> vdly == PTR_W'(NOM));
  end
endmodule

// File: tb/chan_delay_trim_test.sv
module chan_delay_trim_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0]       smp_vld = '0;
  logic [2:0][23:0] volt_in = '0;
  logic [2:0][23:0] curr_in = '0;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_sel = '0;
  logic [4:0]       cfg_code = '0;
  logic [2:0][23:0] volt_out, curr_out;
  logic [2:0]       out_vld;

  always #5 clk = ~clk;

  chan_delay_trim uut (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .volt_in(volt_in),
    .curr_in(curr_in), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_code(cfg_code), .volt_out(volt_out), .curr_out(curr_out),
    .out_vld(out_vld)
  );

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R4";
  bit cmp_en = 0;
  int tick_n = 0;
  int imp_at = -1;

  // behavioural reference: sample history indexed by sample number
  logic [23:0] vh [3][64];
  logic [23:0] ih [3][64];
  int          cnt [3];
  int          mcode [3];
  logic [23:0] ev [3];
  logic [23:0] ei [3];
  logic        evld [3];

  task automatic chk(string req, string what, logic [23:0] got, logic [23:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < 3; p++) begin
        cnt[p] = 0; mcode[p] = 0; ev[p] = '0; ei[p] = '0; evld[p] = 0;
      end
    end else begin
      for (int p = 0; p < 3; p++) begin
        evld[p] = smp_vld[p];
        if (smp_vld[p]) begin
          int d;
          d = 16 + mcode[p];
          if (d == 0)            ev[p] = volt_in[p];
          else if (cnt[p] >= d)  ev[p] = vh[p][(cnt[p]-d) % 64];
          else                   ev[p] = '0;
          if (cnt[p] >= 16)      ei[p] = ih[p][(cnt[p]-16) % 64];
          else                   ei[p] = '0;
          vh[p][cnt[p] % 64] = volt_in[p];
          ih[p][cnt[p] % 64] = curr_in[p];
          cnt[p]++;
        end
      end
      if (cfg_we && cfg_sel < 3) mcode[cfg_sel] = int'($signed(cfg_code));
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      for (int p = 0; p < 3; p++) begin
        chk("R2", $sformatf("valid ph%0d", p), {23'd0, out_vld[p]}, {23'd0, evld[p]});
        chk(evld[p] ? cur_req : "R10", $sformatf("volt ph%0d", p), volt_out[p], ev[p]);
        chk(evld[p] ? "R3" : "R10", $sformatf("curr ph%0d", p), curr_out[p], ei[p]);
      end
    end
  end

  task automatic put_data(int mode);
    for (int p = 0; p < 3; p++) begin
      if (mode == 0) begin
        volt_in[p] = 24'(p * 65536 + tick_n * 3 + 1);
        curr_in[p] = 24'(24'h800000 + p * 65536 + tick_n * 5 + 2);
      end else begin
        volt_in[p] = (tick_n == imp_at) ? 24'(24'h7ABC00 + p) : 24'h0;
        curr_in[p] = (tick_n == imp_at) ? 24'(24'h35D100 + p) : 24'h0;
      end
    end
  endtask

  task automatic one_tick(int mode);
    @(negedge clk);
    put_data(mode);
    smp_vld = 3'b111;
    @(negedge clk);
    smp_vld = 3'b000;
    repeat (10) @(negedge clk);
    tick_n++;
  endtask

  task automatic wr_code(int sel, logic [4:0] code);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_code = code;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick_n = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      chk("R1", "reset volt", volt_out[p], 24'h0);
      chk("R1", "reset curr", curr_out[p], 24'h0);
      chk("R1", "reset valid", {23'd0, out_vld[p]}, 24'h0);
    end
    cmp_en = 1;

    // R5 R7: code 0 on ramps, including fill-time zeros
    cur_req = "R5";
    repeat (40) one_tick(0);

    // R4 R11: distinct codes per phase: -4, -16, +15
    cur_req = "R4";
    wr_code(0, 5'h1C);
    wr_code(1, 5'h10);
    wr_code(2, 5'h0F);
    repeat (40) one_tick(0);

    // R6: explicit same-strobe pass-through on phase B
    @(negedge clk);
    put_data(0);
    smp_vld = 3'b111;
    @(negedge clk);
    smp_vld = 3'b000;
    chk("R6", "phase B no delay", volt_out[1], volt_in[1]);
    repeat (10) @(negedge clk);
    tick_n++;

    // R7 R4: impulse after reset, fill zeros and exact delay per phase
    cur_req = "R7";
    do_reset();
    wr_code(0, 5'h1C);
    wr_code(1, 5'h00);
    wr_code(2, 5'h0F);
    imp_at = 2;
    repeat (40) one_tick(1);

    // R8: spare select changes nothing
    cur_req = "R8";
    wr_code(3, 5'h03);
    imp_at = 45;
    repeat (40) one_tick(1);

    // R9: write in the same cycle as a strobe
    cur_req = "R9";
    @(negedge clk);
    put_data(0);
    smp_vld = 3'b111;
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_code = 5'h10;
    @(negedge clk);
    smp_vld = 3'b000;
    cfg_we = 1'b0;
    repeat (10) @(negedge clk);
    tick_n++;
    repeat (36) one_tick(0);

    // R11: strobe only phase C, others must hold
    cur_req = "R11";
    @(negedge clk);
    put_data(0);
    smp_vld = 3'b100;
    @(negedge clk);
    smp_vld = 3'b000;
    repeat (5) @(negedge clk);

    cmp_en = 0;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule